// File: doc/BRIEF.md
# Disk Sector Count and Address Sequencer

This block keeps the task-file sector count and the cylinder, head and sector address of a drive while a multi-sector read or write runs. The host loads the count and the starting address through a small register write port, then a command-start pulse arms the transfer. Each per-sector completion pulse from the data path moves the address forward by one sector and takes one from the count. When the count reaches zero, the transfer is reported complete.

The drive geometry is held locally: the number of sectors on a track and the highest head index. An initialize-geometry pulse copies both from the task-file count and head registers. Sector numbers start at one. When the last sector on a track is passed, the sector number wraps to one and the head advances. When the last head is passed, the head returns to zero and the cylinder advances. An error pulse stops the transfer and leaves every register showing the sector that failed and the sectors still owed.

Top module: `dsk_sector_seq`

## Requirements
- R1: After reset the count reads 0, the sector reads 1, head and cylinder read 0, and busy, complete, error, overrun, head-wrap and cylinder-wrap are all low. The geometry is 17 sectors per track and a highest head index of 3.
- R2: A write with `wr_en` high loads the register picked by `wr_sel`: 0 the count, 1 the sector, 2 the cylinder low byte, 3 the cylinder high byte, 4 the head (low `HEAD_W` bits of the data). Writes and geometry loads made while busy have no effect.
- R3: A command start while idle raises busy. A stored count of 0 requests 256 sectors, so the count shows 255 after the first completed sector.
- R4: Each completed sector while busy takes one from the count. When the count reaches 0, busy falls and the complete flag rises, both in the same cycle.
- R5: Each completed sector adds one to the sector number. A sector at or above the sectors-per-track value goes back to 1 instead, the head advances, and `head_wrap` pulses for one cycle.
- R6: When the head advances past the highest head index, it returns to 0, the cylinder adds one, and `cyl_wrap` pulses together with `head_wrap`.
- R7: An initialize-geometry pulse while idle takes sectors per track from the count register and the highest head index from the head register.
- R8: An error pulse while busy drops busy, sets the error flag, and freezes count, sector, head and cylinder. An error in the same cycle as a sector completion wins, and the sector is not counted.
- R9: A sector-completion pulse while not busy changes no register and sets the overrun flag.
- R10: A command start while the sector register holds 0 sets the error flag at once. It does not raise busy and changes no register.
- R11: A command start while idle clears the complete, error and overrun flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for a write |
| wr_data | input | TF_W | Write data |
| init_geom | input | 1 | Load geometry from count and head registers |
| cmd_start | input | 1 | Start a multi-sector transfer |
| sec_done | input | 1 | One sector transferred successfully |
| xfer_err | input | 1 | Transfer failed on the current sector |
| cur_count | output | TF_W | Sectors still to transfer (0 also means 256 before start) |
| cur_sector | output | TF_W | Current sector number |
| cur_head | output | HEAD_W | Current head |
| cur_cyl | output | 2*TF_W | Current cylinder |
| busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | Transfer completed with count exhausted |
| err_flag | output | 1 | Transfer stopped by an error or a bad start |
| overrun | output | 1 | Sector completion seen while not busy |
| head_wrap | output | 1 | One-cycle pulse: sector wrapped to 1 |
| cyl_wrap | output | 1 | One-cycle pulse: head wrapped to 0 |

## Verification
The bench targets the wrap points. It starts a transfer one sector before the end of a track on the last head, with the cylinder low byte at 0xFF. A design that compares against the wrong limit, or carries badly between the cylinder bytes, shows the wrong sector, head or cylinder, or misses a wrap pulse. A start with a count of zero must run as 256 sectors and show 255 after one sector; a design that treats zero literally would finish at once. The bench also fires an error together with a sector completion, and a completion after the count is exhausted. A design that counts the failed sector, or advances the address on a stray pulse, shows a moved register instead of the frozen one.

// File: rtl/dsk_seq_pkg.sv
package dsk_seq_pkg;

    typedef enum logic [2:0] {
        SEL_COUNT  = 3'd0,
        SEL_SECTOR = 3'd1,
        SEL_CYL_LO = 3'd2,
        SEL_CYL_HI = 3'd3,
        SEL_HEAD   = 3'd4
    } tf_sel_e;

endpackage

// File: rtl/dsk_geom_store.sv
module dsk_geom_store #(
    parameter int TF_W    = 8,
    parameter int HEAD_W  = 4,
    parameter int DEF_SPT = 17,
    parameter int DEF_HM1 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TF_W-1:0]   spt_in,
    input  logic [HEAD_W-1:0] hm1_in,
    output logic [TF_W-1:0]   spt,
    output logic [HEAD_W-1:0] hm1
);

    typedef struct packed {
        logic [TF_W-1:0]   spt;
        logic [HEAD_W-1:0] hm1;
    } geom_t;

    geom_t geom_d, geom_q;

    always_comb begin
        geom_d = geom_q;
        if (load) begin
            geom_d.spt = spt_in;
            geom_d.hm1 = hm1_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            geom_q.spt <= TF_W'(DEF_SPT);
            geom_q.hm1 <= HEAD_W'(DEF_HM1);
        end else begin
            geom_q <= geom_d;
        end
    end

    assign spt = geom_q.spt;
    assign hm1 = geom_q.hm1;

endmodule

// File: rtl/dsk_chs_step.sv
module dsk_chs_step #(
    parameter int TF_W   = 8,
    parameter int HEAD_W = 4,
    parameter int CYL_W  = 16
) (
    input  logic [TF_W-1:0]   sec,
    input  logic [HEAD_W-1:0] head,
    input  logic [CYL_W-1:0]  cyl,
    input  logic [TF_W-1:0]   spt,
    input  logic [HEAD_W-1:0] hm1,
    output logic [TF_W-1:0]   sec_nx,
    output logic [HEAD_W-1:0] head_nx,
    output logic [CYL_W-1:0]  cyl_nx,
    output logic              hwrap,
    output logic              cwrap
);

    logic track_end;
    logic head_end;

    assign track_end = (sec >= spt);
    assign head_end  = (head >= hm1);

    always_comb begin
        sec_nx  = sec + TF_W'(1);
        head_nx = head;
        cyl_nx  = cyl;
        hwrap   = 1'b0;
        cwrap   = 1'b0;
        if (track_end) begin
            sec_nx = TF_W'(1);
            hwrap  = 1'b1;
            if (head_end) begin
                head_nx = '0;
                cyl_nx  = cyl + CYL_W'(1);
                cwrap   = 1'b1;
            end else begin
                head_nx = head + HEAD_W'(1);
            end
        end
    end

endmodule

// File: rtl/dsk_sector_seq.sv
module dsk_sector_seq #(
    parameter int TF_W    = 8,
    parameter int HEAD_W  = 4,
    parameter int DEF_SPT = 17,
    parameter int DEF_HM1 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [TF_W-1:0]   wr_data,
    input  logic              init_geom,
    input  logic              cmd_start,
    input  logic              sec_done,
    input  logic              xfer_err,
    output logic [TF_W-1:0]   cur_count,
    output logic [TF_W-1:0]   cur_sector,
    output logic [HEAD_W-1:0] cur_head,
    output logic [2*TF_W-1:0] cur_cyl,
    output logic              busy,
    output logic              xfer_done,
    output logic              err_flag,
    output logic              overrun,
    output logic              head_wrap,
    output logic              cyl_wrap
);
    import dsk_seq_pkg::*;

    localparam int CYL_W = 2 * TF_W;
    localparam int REM_W = TF_W + 1;
    localparam logic [REM_W-1:0] FULL_RUN = REM_W'(1) << TF_W;

    typedef struct packed {
        logic [REM_W-1:0]  rem;
        logic [TF_W-1:0]   sec;
        logic [HEAD_W-1:0] head;
        logic [CYL_W-1:0]  cyl;
        logic              busy;
        logic              done;
        logic              err;
        logic              ovr;
        logic              hwrap;
        logic              cwrap;
    } seq_t;

    seq_t st_d, st_q;

    logic [TF_W-1:0]   spt;
    logic [HEAD_W-1:0] hm1;
    logic              geom_load;
    logic [TF_W-1:0]   sec_nx;
    logic [HEAD_W-1:0] head_nx;
    logic [CYL_W-1:0]  cyl_nx;
    logic              step_hwrap;
    logic              step_cwrap;

    assign geom_load = init_geom && !st_q.busy;

    dsk_geom_store #(
        .TF_W    (TF_W),
        .HEAD_W  (HEAD_W),
        .DEF_SPT (DEF_SPT),
        .DEF_HM1 (DEF_HM1)
    ) u_geom (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (geom_load),
        .spt_in (st_q.rem[TF_W-1:0]),
        .hm1_in (st_q.head),
        .spt    (spt),
        .hm1    (hm1)
    );

    dsk_chs_step #(
        .TF_W   (TF_W),
        .HEAD_W (HEAD_W),
        .CYL_W  (CYL_W)
    ) u_step (
        .sec     (st_q.sec),
        .head    (st_q.head),
        .cyl     (st_q.cyl),
        .spt     (spt),
        .hm1     (hm1),
        .sec_nx  (sec_nx),
        .head_nx (head_nx),
        .cyl_nx  (cyl_nx),
        .hwrap   (step_hwrap),
        .cwrap   (step_cwrap)
    );

    always_comb begin
        st_d       = st_q;
        st_d.hwrap = 1'b0;
        st_d.cwrap = 1'b0;
        if (!st_q.busy) begin
            if (wr_en) begin
                case (tf_sel_e'(wr_sel))
                    SEL_COUNT:  st_d.rem  = {1'b0, wr_data};
                    SEL_SECTOR: st_d.sec  = wr_data;
                    SEL_CYL_LO: st_d.cyl[TF_W-1:0] = wr_data;
                    SEL_CYL_HI: st_d.cyl[CYL_W-1:TF_W] = wr_data;
                    SEL_HEAD:   st_d.head = wr_data[HEAD_W-1:0];
                    default:    ;
                endcase
            end
            if (sec_done) begin
                st_d.ovr = 1'b1;
            end
            if (cmd_start) begin
                st_d.done = 1'b0;
                st_d.ovr  = 1'b0;
                if (st_q.sec == '0) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.err  = 1'b0;
                    st_d.busy = 1'b1;
                    if (st_q.rem == '0) begin
                        st_d.rem = FULL_RUN;
                    end
                end
            end
        end else begin
            if (xfer_err) begin
                st_d.busy = 1'b0;
                st_d.err  = 1'b1;
            end else if (sec_done) begin
                st_d.sec   = sec_nx;
                st_d.head  = head_nx;
                st_d.cyl   = cyl_nx;
                st_d.hwrap = step_hwrap;
                st_d.cwrap = step_cwrap;
                st_d.rem   = st_q.rem - REM_W'(1);
                if (st_q.rem == REM_W'(1)) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.sec <= TF_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_count  = st_q.rem[TF_W-1:0];
    assign cur_sector = st_q.sec;
    assign cur_head   = st_q.head;
    assign cur_cyl    = st_q.cyl;
    assign busy       = st_q.busy;
    assign xfer_done  = st_q.done;
    assign err_flag   = st_q.err;
    assign overrun    = st_q.ovr;
    assign head_wrap  = st_q.hwrap;
    assign cyl_wrap   = st_q.cwrap;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sec_done && !xfer_err) |=> (st_q.rem == $past(st_q.rem) - REM_W'(1))) else $error("count step"); // R4
    AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done) |-> (st_q.rem == '0 && !busy)) else $error("done with count left"); // R4
    AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && xfer_err) |=> ($stable(cur_count) && $stable(cur_sector) && $stable(cur_cyl) && err_flag && !busy)) else $error("error freeze"); // R8
    AST_SECTOR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cur_sector != '0)) else $error("zero sector while busy"); // R10
    AST_BAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_start && !wr_en && cur_sector == '0) |=> (err_flag && !busy && $stable(cur_count))) else $error("bad start"); // R10
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sec_done && !cmd_start) |=> (overrun && $stable(cur_sector))) else $error("overrun"); // R9
    AST_WRAP_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        head_wrap |-> (cur_sector == TF_W'(1))) else $error("wrap sector"); // R5
    AST_CYL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        cyl_wrap |-> (head_wrap && cur_head == '0)) else $error("cylinder wrap"); // R6

endmodule

// File: tb/dsk_sector_seq_bench.sv
module dsk_sector_seq_bench;

    localparam int K_IDLE  = 0;
    localparam int K_WR    = 1;
    localparam int K_INIT  = 2;
    localparam int K_START = 3;
    localparam int K_DONE  = 4;
    localparam int K_ERR   = 5;
    localparam int K_BOTH  = 6;

    typedef struct {
        int    cnt;
        int    sec;
        int    head;
        int    cyl;
        int    busy;
        int    done;
        int    err;
        int    ovr;
        int    hw;
        int    cw;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       init_geom = 1'b0;
    logic       cmd_start = 1'b0;
    logic       sec_done = 1'b0;
    logic       xfer_err = 1'b0;
    logic [7:0]  cur_count;
    logic [7:0]  cur_sector;
    logic [3:0]  cur_head;
    logic [15:0] cur_cyl;
    logic busy, xfer_done, err_flag, overrun, head_wrap, cyl_wrap;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];

    int m_rem, m_sec, m_head, m_cyl, m_spt, m_hm1;
    int m_busy, m_done, m_err, m_ovr, m_hw, m_cw;

    always #4 clk = ~clk;

    dsk_sector_seq u_dsk_sector_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .init_geom(init_geom), .cmd_start(cmd_start), .sec_done(sec_done), .xfer_err(xfer_err),
        .cur_count(cur_count), .cur_sector(cur_sector), .cur_head(cur_head), .cur_cyl(cur_cyl),
        .busy(busy), .xfer_done(xfer_done), .err_flag(err_flag), .overrun(overrun),
        .head_wrap(head_wrap), .cyl_wrap(cyl_wrap)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // monitor: compare outputs against expected items away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.tag, "count",   int'(cur_count),  e.cnt);
                cmp(e.tag, "sector",  int'(cur_sector), e.sec);
                cmp(e.tag, "head",    int'(cur_head),   e.head);
                cmp(e.tag, "cyl",     int'(cur_cyl),    e.cyl);
                cmp(e.tag, "busy",    int'(busy),       e.busy);
                cmp(e.tag, "done",    int'(xfer_done),  e.done);
                cmp(e.tag, "err",     int'(err_flag),   e.err);
                cmp(e.tag, "overrun", int'(overrun),    e.ovr);
                cmp(e.tag, "hwrap",   int'(head_wrap),  e.hw);
                cmp(e.tag, "cwrap",   int'(cyl_wrap),   e.cw);
            end
        end
    end

    task automatic model_advance();
        if (m_sec >= m_spt) begin
            m_sec = 1;
            m_hw  = 1;
            if (m_head >= m_hm1) begin
                m_head = 0;
                m_cyl  = (m_cyl + 1) % 65536;
                m_cw   = 1;
            end else begin
                m_head = m_head + 1;
            end
        end else begin
            m_sec = m_sec + 1;
        end
    endtask

    // driver: apply one operation, update the expectation, queue it
    task automatic step(input int kind, input int sel, input int data, input string tag);
        exp_t e;
        @(negedge clk);
        m_hw = 0;
        m_cw = 0;
        case (kind)
            K_WR: begin
                wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 8'(data);
                if (m_busy == 0) begin
                    case (sel)
                        0: m_rem = data;
                        1: m_sec = data;
                        2: m_cyl = (m_cyl & 16'hFF00) | data;
                        3: m_cyl = (m_cyl & 16'h00FF) | (data << 8);
                        4: m_head = data % 16;
                        default: ;
                    endcase
                end
            end
            K_INIT: begin
                init_geom = 1'b1;
                if (m_busy == 0) begin
                    m_spt = m_rem % 256;
                    m_hm1 = m_head;
                end
            end
            K_START: begin
                cmd_start = 1'b1;
                if (m_busy == 0) begin
                    m_done = 0;
                    m_ovr  = 0;
                    if (m_sec == 0) m_err = 1;
                    else begin
                        m_err  = 0;
                        m_busy = 1;
                        if (m_rem == 0) m_rem = 256;
                    end
                end
            end
            K_DONE, K_ERR, K_BOTH: begin
                sec_done = (kind != K_ERR);
                xfer_err = (kind != K_DONE);
                if (m_busy != 0) begin
                    if (kind != K_DONE) begin
                        m_busy = 0;
                        m_err  = 1;
                    end else begin
                        model_advance();
                        m_rem = m_rem - 1;
                        if (m_rem == 0) begin
                            m_busy = 0;
                            m_done = 1;
                        end
                    end
                end else if (kind != K_ERR) begin
                    m_ovr = 1;
                end
            end
            default: ;
        endcase
        @(posedge clk);
        #1;
        wr_en = 1'b0; init_geom = 1'b0; cmd_start = 1'b0; sec_done = 1'b0; xfer_err = 1'b0;
        e.cnt = m_rem % 256; e.sec = m_sec; e.head = m_head; e.cyl = m_cyl;
        e.busy = m_busy; e.done = m_done; e.err = m_err; e.ovr = m_ovr;
        e.hw = m_hw; e.cw = m_cw; e.tag = tag;
        q.push_back(e);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        m_rem = 0; m_sec = 1; m_head = 0; m_cyl = 0; m_spt = 17; m_hm1 = 3;
        m_busy = 0; m_done = 0; m_err = 0; m_ovr = 0; m_hw = 0; m_cw = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step(K_IDLE, 0, 0, "R1 reset state");

        // R7: geometry of 4 sectors per track, highest head 1
        step(K_WR, 0, 4, "R2 write count");
        step(K_WR, 4, 1, "R2 write head");
        step(K_INIT, 0, 0, "R7 load geometry");

        // R5 track wrap inside one transfer
        step(K_WR, 2, 8'hFF, "R2 cyl low");
        step(K_WR, 3, 8'h12, "R2 cyl high");
        step(K_WR, 4, 0, "R2 head");
        step(K_WR, 1, 3, "R2 sector");
        step(K_WR, 0, 3, "R2 count");
        step(K_START, 0, 0, "R3 start");
        step(K_DONE, 0, 0, "R4 first sector");
        step(K_DONE, 0, 0, "R5 track wrap");
        step(K_DONE, 0, 0, "R4 complete");
        step(K_IDLE, 0, 0, "R5 wrap pulse ends");

        // R9 stray completion
        step(K_DONE, 0, 0, "R9 overrun");

        // R6 cylinder carry across byte boundary
        step(K_WR, 1, 4, "R2 sector");
        step(K_WR, 0, 2, "R2 count");
        step(K_START, 0, 0, "R11 start clears overrun");
        step(K_DONE, 0, 0, "R6 cylinder wrap");
        step(K_DONE, 0, 0, "R4 complete after wrap");

        // R8 error with simultaneous completion
        step(K_WR, 1, 2, "R2 sector");
        step(K_WR, 0, 5, "R2 count");
        step(K_START, 0, 0, "R3 start");
        step(K_WR, 1, 9, "R2 write ignored busy");
        step(K_WR, 0, 7, "R2 write ignored busy");
        step(K_INIT, 0, 0, "R7 load ignored busy");
        step(K_DONE, 0, 0, "R4 decrement");
        step(K_BOTH, 0, 0, "R8 error wins");
        step(K_DONE, 0, 0, "R9 after error");

        // R3 zero count means 256
        step(K_WR, 0, 0, "R2 count zero");
        step(K_START, 0, 0, "R3 zero count start");
        step(K_DONE, 0, 0, "R3 count 255");
        step(K_DONE, 0, 0, "R3 count 254");
        step(K_ERR, 0, 0, "R8 error freeze");

        // R10 zero sector
        step(K_WR, 1, 0, "R2 sector zero");
        step(K_START, 0, 0, "R10 bad start");
        step(K_DONE, 0, 0, "R9 idle after bad start");

        // R11 restart clears error, single sector run
        step(K_WR, 1, 1, "R2 sector");
        step(K_WR, 0, 1, "R2 count");
        step(K_START, 0, 0, "R11 start clears error");
        step(K_DONE, 0, 0, "R4 single sector");

        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule